// File: doc/BRIEF.md
# Parallel-Port Storage Bridge Attach Sequencer

This block drives the data and control registers of a standard parallel port through the unlock handshake that a parallel-port storage bridge expects before it accepts commands. A single start pulse launches one of three flows. The first is a single unlock pass that carries a caller-supplied mode byte. The second is a complete attach, made of an initialise pass, a connect pass and a short burst of bridge register writes. The third is a detach pass followed by a control write that switches off the activity indicator.

Each unlock pass reads the port status lines at three fixed points, masks each reading and keeps it for diagnostics. The sequencer always finishes. It does not interpret the status readings, and the caller decides what to do with them. Every port write is held for a programmable number of clock cycles, so slow board logic has time to settle.

Top module: `ppa_attach_seq`

## Requirements
- R1: After reset, data_o is 0xFF, ctrl_o is 0x8C, busy_o and done_o are 0, and all three snapshots are 0.
- R2: One unlock pass performs the following steps in order:
  - control 0x04;
  - data 0x22, 0xAA, 0x55, 0x00, 0xFF;
  - first status sample;
  - data 0x87;
  - second status sample;
  - data 0x78;
  - third status sample;
  - data = the pass's mode byte;
  - control 0x04, 0x05, 0x04;
  - data 0xFF.
- R3: The first snapshot is status_i AND 0xB8, taken while data_o shows 0xFF. The second is status_i AND 0xB8, taken while data_o shows 0x87. The third is status_i AND 0x38, taken while data_o shows 0x78. Snapshots keep their value until a later pass overwrites them.
- R4: op_i selects the flow at the start pulse:
  - 0 or 3: one pass using mode_i;
  - 1: full attach;
  - 2: detach.
  mode_i is used only by op 0 and op 3.
- R5: Full attach runs these steps in order:
  - a pass with mode 0x00;
  - a pass with mode 0xE0;
  - data 0x00, then control 0x01, then control 0x04;
  - four register writes, in this order: 0x10 to 0x08, 0x14 to 0x0C, 0x38 to 0x0A, 0x10 to 0x12.

  Each register write is four port writes: data = 0x60 + address, control 0x01, data = value, control 0x04.
- R6: Detach runs a pass with mode 0x30, then writes 0x8C to the control port.
- R7: Every port write appears on its port in the cycle after its issuing edge. It stays there for H cycles, where H = hold_i, or 1 when hold_i is 0. A status sample takes one cycle. The first write appears one cycle after busy_o rises.
- R8: busy_o rises in the cycle after an accepted start pulse. It stays high until the hold of the final write has elapsed. done_o is high for exactly the one cycle after busy_o falls.
- R9: op_i, mode_i and hold_i are captured at the accepted start pulse; later changes to them have no effect. A start pulse while busy_o is high is ignored.
- R10: While busy_o is low, data_o and ctrl_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| op_i | input | 2 | Flow select (see R4) |
| mode_i | input | 8 | Mode byte for a single pass |
| hold_i | input | HOLD_W | Cycles each port write is held (0 acts as 1) |
| status_i | input | 8 | Parallel-port status lines |
| data_o | output | 8 | Data port value |
| ctrl_o | output | 8 | Control port value including indicator bit 7 |
| snap1_o | output | 8 | First masked status snapshot |
| snap2_o | output | 8 | Second masked status snapshot |
| snap3_o | output | 8 | Third masked status snapshot |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench feeds status_i as data_o XOR a per-run key, so each snapshot depends on the byte on the data port at the moment of sampling. A sample taken one step early or late, or with the wrong mask, therefore yields a different value. Directed runs cover each flow, a zero hold, the largest hold and a start pulse while busy. These runs show that the step order, the tail of each flow and the pacing are separate from one another. Randomised runs mix flows, mode bytes, holds and keys, and scramble the inputs after the start pulse to show that they were captured at start. Each run is compared cycle by cycle against an independently built step list.

// File: rtl/ppa_attach_pkg.sv
package ppa_attach_pkg;
  typedef enum logic [1:0] {ACT_DATA = 2'd0, ACT_CTRL = 2'd1, ACT_SNAP = 2'd2} act_e;
  typedef enum logic [1:0] {OP_PASS = 2'd0, OP_CONN = 2'd1, OP_DISC = 2'd2, OP_PASS_ALT = 2'd3} op_e;

  typedef struct packed {
    act_e       act;
    logic [1:0] sel;
    logic [7:0] val;
  } step_t;

  localparam int PASS_LEN   = 16;
  localparam int REG_WR_CNT = 4;
  localparam int CONN_LEN   = 2 * PASS_LEN + 3 + 4 * REG_WR_CNT;
  localparam int DISC_LEN   = PASS_LEN + 1;
  localparam int PC_W       = $clog2(CONN_LEN);

  localparam logic [7:0] MODE_INIT = 8'h00;
  localparam logic [7:0] MODE_CONN = 8'hE0;
  localparam logic [7:0] MODE_DISC = 8'h30;
  localparam logic [7:0] DATA_IDLE = 8'hFF;
  localparam logic [7:0] CTRL_IDLE = 8'h8C;
endpackage

// File: rtl/ppa_attach_prog.sv
module ppa_attach_prog
  import ppa_attach_pkg::*;
(
  input  op_e             op_i,
  input  logic [7:0]      mode_i,
  input  logic [PC_W-1:0] pc_i,
  output step_t           step_o,
  output logic            last_o
);
  function automatic step_t mk(act_e a, logic [1:0] s, logic [7:0] v);
    step_t t;
    t.act = a;
    t.sel = s;
    t.val = v;
    return t;
  endfunction

  function automatic step_t pass_step(logic [3:0] i, logic [7:0] m);
    case (i)
      4'd0:    return mk(ACT_CTRL, 2'd0, 8'h04);
      4'd1:    return mk(ACT_DATA, 2'd0, 8'h22);
      4'd2:    return mk(ACT_DATA, 2'd0, 8'hAA);
      4'd3:    return mk(ACT_DATA, 2'd0, 8'h55);
      4'd4:    return mk(ACT_DATA, 2'd0, 8'h00);
      4'd5:    return mk(ACT_DATA, 2'd0, 8'hFF);
      4'd6:    return mk(ACT_SNAP, 2'd1, 8'hB8);
      4'd7:    return mk(ACT_DATA, 2'd0, 8'h87);
      4'd8:    return mk(ACT_SNAP, 2'd2, 8'hB8);
      4'd9:    return mk(ACT_DATA, 2'd0, 8'h78);
      4'd10:   return mk(ACT_SNAP, 2'd3, 8'h38);
      4'd11:   return mk(ACT_DATA, 2'd0, m);
      4'd12:   return mk(ACT_CTRL, 2'd0, 8'h04);
      4'd13:   return mk(ACT_CTRL, 2'd0, 8'h05);
      4'd14:   return mk(ACT_CTRL, 2'd0, 8'h04);
      default: return mk(ACT_DATA, 2'd0, 8'hFF);
    endcase
  endfunction

  // bridge register write: address phase, latch, value phase, release
  function automatic step_t reg_step(logic [1:0] r, logic [1:0] ph);
    logic [7:0] addr, val;
    case (r)
      2'd0:    begin addr = 8'h08; val = 8'h10; end
      2'd1:    begin addr = 8'h0C; val = 8'h14; end
      2'd2:    begin addr = 8'h0A; val = 8'h38; end
      default: begin addr = 8'h12; val = 8'h10; end
    endcase
    case (ph)
      2'd0:    return mk(ACT_DATA, 2'd0, 8'h60 + addr);
      2'd1:    return mk(ACT_CTRL, 2'd0, 8'h01);
      2'd2:    return mk(ACT_DATA, 2'd0, val);
      default: return mk(ACT_CTRL, 2'd0, 8'h04);
    endcase
  endfunction

  logic [PC_W-1:0] tail, sub;
  logic [PC_W-1:0] len;

  always_comb begin
    tail = pc_i - PC_W'(2 * PASS_LEN);
    sub  = tail - PC_W'(3);
    case (op_i)
      OP_CONN: len = PC_W'(CONN_LEN);
      OP_DISC: len = PC_W'(DISC_LEN);
      default: len = PC_W'(PASS_LEN);
    endcase
    last_o = (pc_i == len - PC_W'(1));

    if (pc_i < PC_W'(PASS_LEN)) begin
      case (op_i)
        OP_CONN: step_o = pass_step(pc_i[3:0], MODE_INIT);
        OP_DISC: step_o = pass_step(pc_i[3:0], MODE_DISC);
        default: step_o = pass_step(pc_i[3:0], mode_i);
      endcase
    end else if (op_i == OP_CONN && pc_i < PC_W'(2 * PASS_LEN)) begin
      step_o = pass_step(pc_i[3:0], MODE_CONN);
    end else if (op_i == OP_CONN) begin
      case (tail)
        PC_W'(0): step_o = mk(ACT_DATA, 2'd0, 8'h00);
        PC_W'(1): step_o = mk(ACT_CTRL, 2'd0, 8'h01);
        PC_W'(2): step_o = mk(ACT_CTRL, 2'd0, 8'h04);
        default:  step_o = reg_step(sub[3:2], sub[1:0]);
      endcase
    end else begin
      step_o = mk(ACT_CTRL, 2'd0, CTRL_IDLE);
    end
  end
endmodule

// File: rtl/ppa_attach_pace.sv
module ppa_attach_pace #(
  parameter int HOLD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              snap_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              issue_o,
  output logic              adv_o
);
  logic [HOLD_W-1:0] cnt_q;

  assign issue_o = run_i && (cnt_q == '0);
  assign adv_o   = run_i && (snap_i || (cnt_q == hold_i - HOLD_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || adv_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + HOLD_W'(1);
  end
endmodule

// File: rtl/ppa_attach_seq.sv
module ppa_attach_seq
  import ppa_attach_pkg::*;
#(
  parameter int HOLD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [7:0]        mode_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic [7:0]        status_i,
  output logic [7:0]        data_o,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        snap1_o,
  output logic [7:0]        snap2_o,
  output logic [7:0]        snap3_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              busy_q, done_q;
  op_e               op_q;
  logic [7:0]        mode_q, data_q, ctrl_q, s1_q, s2_q, s3_q;
  logic [HOLD_W-1:0] hold_q;
  logic [PC_W-1:0]   pc_q;
  step_t             step;
  logic              last, issue, adv;

  ppa_attach_prog u_prog (
    .op_i   (op_q),
    .mode_i (mode_q),
    .pc_i   (pc_q),
    .step_o (step),
    .last_o (last)
  );

  ppa_attach_pace #(.HOLD_W(HOLD_W)) u_pace (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (busy_q),
    .snap_i  (step.act == ACT_SNAP),
    .hold_i  (hold_q),
    .issue_o (issue),
    .adv_o   (adv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_PASS;
      mode_q <= '0;
      hold_q <= HOLD_W'(1);
      pc_q   <= '0;
      data_q <= DATA_IDLE;
      ctrl_q <= CTRL_IDLE;
      s1_q   <= '0;
      s2_q   <= '0;
      s3_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        op_q   <= op_e'(op_i);
        mode_q <= mode_i;
        hold_q <= (hold_i == '0) ? HOLD_W'(1) : hold_i;
        pc_q   <= '0;
      end
      if (issue) begin
        case (step.act)
          ACT_DATA: data_q <= step.val;
          ACT_CTRL: ctrl_q <= step.val;
          ACT_SNAP: begin
            case (step.sel)
              2'd1:    s1_q <= status_i & step.val;
              2'd2:    s2_q <= status_i & step.val;
              default: s3_q <= status_i & step.val;
            endcase
          end
          default: ;
        endcase
      end
      if (adv) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          pc_q <= pc_q + PC_W'(1);
        end
      end
    end
  end

  assign data_o  = data_q;
  assign ctrl_o  = ctrl_q;
  assign snap1_o = s1_q;
  assign snap2_o = s2_q;
  assign snap3_o = s3_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;
endmodule

// File: rtl/ppa_attach_chk.sv
module ppa_attach_chk #(
  parameter int HOLD_W = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [7:0] data_o,
  input logic [7:0] ctrl_o,
  input logic [7:0] snap1_o,
  input logic [7:0] snap2_o,
  input logic [7:0] snap3_o,
  input logic       busy_o,
  input logic       done_o
);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_busy_from_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_idle_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> ($stable(data_o) && $stable(ctrl_o)));

  assert_snap_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((snap1_o & 8'h47) == 8'h00) && ((snap2_o & 8'h47) == 8'h00) && ((snap3_o & 8'hC7) == 8'h00));
endmodule

bind ppa_attach_seq ppa_attach_chk #(.HOLD_W(HOLD_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .data_o  (data_o),
  .ctrl_o  (ctrl_o),
  .snap1_o (snap1_o),
  .snap2_o (snap2_o),
  .snap3_o (snap3_o),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/ppa_attach_seq_test.sv
module ppa_attach_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD_W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] op_i = '0;
  logic [7:0] mode_i = '0;
  logic [HOLD_W-1:0] hold_i = '0;
  logic [7:0] status_i;
  logic [7:0] data_o, ctrl_o, snap1_o, snap2_o, snap3_o;
  logic busy_o, done_o;
  logic [7:0] key = 8'h00;

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign status_i = data_o ^ key;

  ppa_attach_seq #(.HOLD_W(HOLD_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i), .mode_i(mode_i),
    .hold_i(hold_i), .status_i(status_i), .data_o(data_o), .ctrl_o(ctrl_o),
    .snap1_o(snap1_o), .snap2_o(snap2_o), .snap3_o(snap3_o), .busy_o(busy_o), .done_o(done_o)
  );

  int total = 0;
  int bad = 0;

  // expected step list: kind 0 data, 1 control, 2 sample
  int b_kind [0:63];
  int b_val  [0:63];
  int b_sel  [0:63];
  int n;
  logic [7:0] exp_d = 8'hFF, exp_c = 8'h8C, es1 = 0, es2 = 0, es3 = 0;
  bit run_ok;
  string run_what;
  int run_act, run_exp;

  task automatic check(input bit c, input string tag, input string what, input int act, input int exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic add(input int k, input int v, input int s);
    b_kind[n] = k; b_val[n] = v; b_sel[n] = s; n++;
  endtask

  task automatic add_pass(input int m);
    add(1, 'h04, 0);
    add(0, 'h22, 0); add(0, 'hAA, 0); add(0, 'h55, 0); add(0, 'h00, 0); add(0, 'hFF, 0);
    add(2, 'hB8, 1);
    add(0, 'h87, 0);
    add(2, 'hB8, 2);
    add(0, 'h78, 0);
    add(2, 'h38, 3);
    add(0, m, 0);
    add(1, 'h04, 0); add(1, 'h05, 0); add(1, 'h04, 0);
    add(0, 'hFF, 0);
  endtask

  task automatic build(input int op, input int m);
    int ra [4] = '{'h08, 'h0C, 'h0A, 'h12};
    int rv [4] = '{'h10, 'h14, 'h38, 'h10};
    n = 0;
    if (op == 1) begin
      add_pass('h00);
      add_pass('hE0);
      add(0, 'h00, 0); add(1, 'h01, 0); add(1, 'h04, 0);
      for (int r = 0; r < 4; r++) begin
        add(0, 'h60 + ra[r], 0); add(1, 'h01, 0); add(0, rv[r], 0); add(1, 'h04, 0);
      end
    end else if (op == 2) begin
      add_pass('h30);
      add(1, 'h8C, 0);
    end else begin
      add_pass(m);
    end
  endtask

  task automatic cmp(input int a, input int e, input string what);
    if (run_ok && a != e) begin
      run_ok = 0; run_what = what; run_act = a; run_exp = e;
    end
  endtask

  task automatic run(input int op, input int m, input int hold, input string tag, input bit poke);
    int h;
    int edge_n;
    bit last;
    logic [7:0] e;
    build(op, m);
    h = (hold == 0) ? 1 : hold;
    @(negedge clk);
    start_i = 1'b1; op_i = 2'(op); mode_i = 8'(m); hold_i = HOLD_W'(hold);
    @(negedge clk);
    start_i = 1'b0; op_i = 2'($urandom); mode_i = 8'($urandom); hold_i = HOLD_W'($urandom);
    run_ok = 1; edge_n = 0;
    cmp(busy_o, 1, "busy after start (R8)");
    for (int i = 0; i < n; i++) begin
      if (b_kind[i] == 2) begin
        @(negedge clk); edge_n++;
        e = (exp_d ^ key) & 8'(b_val[i]);
        if (b_sel[i] == 1) es1 = e; else if (b_sel[i] == 2) es2 = e; else es3 = e;
        cmp(data_o, exp_d, "data during sample (R2)");
        cmp(busy_o, 1, "busy (R8)");
        if (poke && edge_n == 3) start_i = 1'b1;
        if (poke && edge_n == 4) start_i = 1'b0;
      end else begin
        if (b_kind[i] == 0) exp_d = 8'(b_val[i]); else exp_c = 8'(b_val[i]);
        for (int k = 0; k < h; k++) begin
          @(negedge clk); edge_n++;
          last = (i == n - 1) && (k == h - 1);
          cmp(data_o, exp_d, $sformatf("data at step %0d (R2/R7)", i));
          cmp(ctrl_o, exp_c, $sformatf("ctrl at step %0d (R2/R7)", i));
          cmp(busy_o, !last, "busy (R8)");
          cmp(done_o, last, "done (R8)");
          if (poke && edge_n == 3) start_i = 1'b1;
          if (poke && edge_n == 4) start_i = 1'b0;
        end
      end
    end
    check(run_ok, tag, run_what, run_act, run_exp);
    @(negedge clk);
    check(!done_o && !busy_o && data_o == exp_d && ctrl_o == exp_c, "R10",
          "idle after done, data/ctrl/busy/done", {data_o, ctrl_o, 6'b0, busy_o, done_o},
          {exp_d, exp_c, 8'h00});
    check(snap1_o == es1, "R3", "snapshot 1", snap1_o, es1);
    check(snap2_o == es2, "R3", "snapshot 2", snap2_o, es2);
    check(snap3_o == es3, "R3", "snapshot 3", snap3_o, es3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(data_o == 8'hFF, "R1", "reset data", data_o, 8'hFF);
    check(ctrl_o == 8'h8C, "R1", "reset ctrl", ctrl_o, 8'h8C);
    check(!busy_o && !done_o, "R1", "reset busy/done", {busy_o, done_o}, 0);
    check(snap1_o == 0 && snap2_o == 0 && snap3_o == 0, "R1", "reset snapshots",
          {snap1_o, snap2_o, snap3_o}, 0);

    key = 8'h5C; run(0, 'h5A, 1, "R2", 0);
    key = 8'hA3; run(1, 'h00, 2, "R5", 0);
    key = 8'h0F; run(2, 'hEE, 3, "R6", 0);
    key = 8'hF0; run(3, 'hC3, 1, "R4", 0);
    key = 8'h81; run(0, 'h11, 0, "R7", 0);
    key = 8'h3E; run(0, 'h99, 15, "R7", 0);
    key = 8'h77; run(1, 'h42, 1, "R9", 1);
    key = 8'h12; run(2, 'h24, 2, "R9", 1);

    for (int t = 0; t < 30; t++) begin
      key = 8'($urandom);
      run(int'($urandom_range(0, 3)), int'($urandom_range(0, 255)),
          int'($urandom_range(0, 5)), "R4", bit'($urandom_range(0, 1)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule